// File: doc/BRIEF.md
# Ethernet PAUSE Frame Receive Classifier

This block watches received Ethernet frames one byte per beat. Each frame is marked by a start flag on its first byte and an end flag on its last byte, and the CRC verdict arrives with the end flag. From that stream the block works out three things: whether the frame is a MAC control frame, whether it is a PAUSE frame, and whether it should be written to the receive FIFO or dropped. When a valid PAUSE frame arrives and receive flow control is enabled, the block emits a one-cycle pause request that carries the 16-bit pause time. It also loads a quanta counter that holds off the transmitter.

The normal address filter result comes in on `addr_match`. Two configuration inputs are independent of each other. `cfg_rx_fc_en` decides whether PAUSE frames are acted on. `cfg_pass_all` decides whether control frames are forwarded. The reserved PAUSE multicast destination is accepted whatever the filter says.

Top module: `pause_rx_classifier`

## Requirements
- R1: A frame whose bytes 12 and 13 (counted from 0 at the start-of-frame byte) are 0x88 then 0x08 is reported as a control frame (`dec_ctrl`=1). Any other frame, including one shorter than 14 bytes, gives `dec_ctrl`=0.
- R2: `dec_pause`=1 exactly when the frame is a control frame, bytes 0-5 are 01,80,C2,00,00,01, bytes 14-15 are 0x00 then 0x01, and the frame is at least 18 bytes long.
- R3: A frame addressed to 01-80-C2-00-00-01 is accepted even when `addr_match`=0. Every other frame, control frames included, is accepted only when `addr_match`=1 on its end beat. A frame that is not accepted has `dec_forward`=0.
- R4: `pause_req` pulses for one cycle, in the cycle after the end beat, only for a PAUSE frame with `rx_crc_ok`=1 and `cfg_rx_fc_en`=1. While it pulses, `pause_time` holds bytes 16 and 17 as a big-endian value.
- R5: With `cfg_pass_all`=0, an accepted control frame gives `dec_forward`=0.
- R6: With `cfg_pass_all`=1, every accepted frame gives `dec_forward`=1, control or not, whatever `cfg_rx_fc_en` is. Non-control accepted frames always give `dec_forward`=1, and CRC status does not affect forwarding.
- R7: A pause request reloads the quanta counter. `tx_hold` is high, in the same cycle as `pause_req`, exactly when the new pause time is nonzero. A pause time of zero drops `tx_hold` at once.
- R8: Each cycle with `quanta_tick`=1 and no reload lowers the counter by one. After N ticks from a load of N, `tx_hold` falls. `tx_hold` never rises without `pause_req`.
- R9: `dec_valid` pulses in the cycle after each end beat, and the frame's decision fields are valid with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Byte beat valid |
| rx_data | input | 8 | Received byte |
| rx_sof | input | 1 | Beat is the first byte of a frame |
| rx_eof | input | 1 | Beat is the last byte of a frame |
| rx_crc_ok | input | 1 | CRC good, qualified by the end beat |
| addr_match | input | 1 | Normal address filter result, sampled on the end beat |
| cfg_rx_fc_en | input | 1 | Act on received PAUSE frames |
| cfg_pass_all | input | 1 | Forward control frames to the FIFO |
| quanta_tick | input | 1 | One pulse per 512 bit times |
| dec_valid | output | 1 | Frame decision valid |
| dec_forward | output | 1 | Write frame to receive FIFO |
| dec_ctrl | output | 1 | Frame is a control frame |
| dec_pause | output | 1 | Frame is a PAUSE frame |
| pause_req | output | 1 | Pause request pulse |
| pause_time | output | 16 | Pause time carried by the request |
| tx_hold | output | 1 | Transmit hold while the quanta counter is nonzero |

## Verification
The bench goes after frames that almost qualify. These include a wrong last destination byte, a wrong opcode, and a PAUSE header cut short before the time field. A design that decides on a partial match would flag such frames as PAUSE frames and stall the transmitter. It also sends the reserved address with the filter result low, which a design that routes it through the normal filter would drop. The two enable bits are crossed in all four combinations, so that mixing up acting on a frame with forwarding it shows up as a wrong forward bit or a stray request. On the hold counter, the bench checks the exact tick count, a reload with zero during a hold, and a bad-CRC PAUSE frame, which must leave the hold untouched.

// File: rtl/pause_rx_classifier.sv
module pause_rx_classifier (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_sof,
  input  logic        rx_eof,
  input  logic        rx_crc_ok,
  input  logic        addr_match,
  input  logic        cfg_rx_fc_en,
  input  logic        cfg_pass_all,
  input  logic        quanta_tick,
  output logic        dec_valid,
  output logic        dec_forward,
  output logic        dec_ctrl,
  output logic        dec_pause,
  output logic        pause_req,
  output logic [15:0] pause_time,
  output logic        tx_hold
);
  localparam logic [47:0] RSV_DA   = 48'h0180C2000001;
  localparam logic [15:0] CTL_TYPE = 16'h8808;
  localparam logic [15:0] OP_PAUSE = 16'h0001;
  localparam int          IW       = 5;

  logic [IW-1:0] cnt, idx;
  logic          da_run, typ_run, op_run;
  logic          da_run_n, typ_run_n, op_run_n;
  logic [15:0]   ptime, ptime_n;
  logic [15:0]   quanta;
  logic [7:0]    da_byte;
  logic          da_ok, ctl_n, op_ok, long_enough, pause_n, accept, load;

  assign idx = rx_sof ? '0 : cnt;

  always_comb begin
    case (idx)
      5'd0:    da_byte = RSV_DA[47:40];
      5'd1:    da_byte = RSV_DA[39:32];
      5'd2:    da_byte = RSV_DA[31:24];
      5'd3:    da_byte = RSV_DA[23:16];
      5'd4:    da_byte = RSV_DA[15:8];
      default: da_byte = RSV_DA[7:0];
    endcase
  end

  always_comb begin
    da_run_n  = da_run;
    typ_run_n = (idx == 0) ? 1'b0 : typ_run;
    op_run_n  = (idx == 0) ? 1'b0 : op_run;
    ptime_n   = ptime;
    if (idx < 6)
      da_run_n = ((idx == 0) || da_run) && (rx_data == da_byte);
    case (idx)
      5'd12: typ_run_n = (rx_data == CTL_TYPE[15:8]);
      5'd13: typ_run_n = typ_run && (rx_data == CTL_TYPE[7:0]);
      5'd14: op_run_n  = (rx_data == OP_PAUSE[15:8]);
      5'd15: op_run_n  = op_run && (rx_data == OP_PAUSE[7:0]);
      5'd16: ptime_n   = {rx_data, ptime[7:0]};
      5'd17: ptime_n   = {ptime[15:8], rx_data};
      default: ;
    endcase
  end

  assign da_ok       = da_run_n && (idx >= 5);
  assign ctl_n       = typ_run_n && (idx >= 13);
  assign op_ok       = op_run_n && (idx >= 15);
  assign long_enough = (idx >= 17);
  assign pause_n     = ctl_n && da_ok && op_ok && long_enough;
  assign accept      = da_ok || addr_match;
  assign load        = rx_valid && rx_eof && pause_n && rx_crc_ok && cfg_rx_fc_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      da_run  <= 1'b0;
      typ_run <= 1'b0;
      op_run  <= 1'b0;
      ptime   <= '0;
    end else if (rx_valid) begin
      cnt     <= (idx == '1) ? idx : idx + 1'b1;
      da_run  <= da_run_n;
      typ_run <= typ_run_n;
      op_run  <= op_run_n;
      ptime   <= ptime_n;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid   <= 1'b0;
      dec_forward <= 1'b0;
      dec_ctrl    <= 1'b0;
      dec_pause   <= 1'b0;
      pause_req   <= 1'b0;
      pause_time  <= '0;
    end else begin
      dec_valid <= rx_valid && rx_eof;
      pause_req <= load;
      if (rx_valid && rx_eof) begin
        dec_forward <= accept && (!ctl_n || cfg_pass_all);
        dec_ctrl    <= ctl_n;
        dec_pause   <= pause_n;
      end
      if (load) pause_time <= ptime_n;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                         quanta <= '0;
    else if (load)                      quanta <= ptime_n;
    else if (quanta_tick && quanta != 0) quanta <= quanta - 1'b1;
  end

  assign tx_hold = (quanta != 0);
endmodule

module pause_rx_classifier_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_rx_fc_en,
  input logic        cfg_pass_all,
  input logic        quanta_tick,
  input logic        dec_valid,
  input logic        dec_forward,
  input logic        dec_ctrl,
  input logic        dec_pause,
  input logic        pause_req,
  input logic [15:0] pause_time,
  input logic        tx_hold
);
  assert_pause_is_ctrl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && dec_pause |-> dec_ctrl);
  assert_req_needs_fc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pause_req |-> $past(cfg_rx_fc_en) && dec_valid && dec_pause);
  assert_ctrl_dropped_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && dec_ctrl && !$past(cfg_pass_all) |-> !dec_forward);
  assert_hold_on_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pause_req |-> tx_hold == (pause_time != 16'd0));
  assert_hold_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_hold) |-> pause_req);
  assert_hold_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_hold) |-> pause_req || $past(quanta_tick));
endmodule

bind pause_rx_classifier pause_rx_classifier_chk u_chk (.*);

// File: tb/pause_rx_classifier_test.sv
module pause_rx_classifier_test;
  logic clk = 0, rst_n = 0;
  logic rx_valid = 0, rx_sof = 0, rx_eof = 0, rx_crc_ok = 0, addr_match = 0;
  logic [7:0] rx_data = 0;
  logic cfg_rx_fc_en = 0, cfg_pass_all = 0, quanta_tick = 0;
  logic dec_valid, dec_forward, dec_ctrl, dec_pause, pause_req, tx_hold;
  logic [15:0] pause_time;
  int checks = 0, fails = 0;
  logic [19:0] expq[$];

  localparam logic [47:0] RDA = 48'h0180C2000001;
  localparam logic [47:0] UDA = 48'h0A1B2C3D4E5F;

  always #5 clk = ~clk;

  pause_rx_classifier uut (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [47:0] da, input logic [15:0] ty, input logic [15:0] op,
                      input logic [15:0] pt, input int len, input bit crc, input bit am);
    bit isdar, ctl, pse, fwd, req;
    isdar = (da == RDA);
    ctl = (len >= 14) && (ty == 16'h8808);
    pse = ctl && isdar && (op == 16'h0001) && (len >= 18);
    fwd = (isdar || am) && (!ctl || cfg_pass_all);
    req = pse && crc && cfg_rx_fc_en;
    expq.push_back({fwd, ctl, pse, req, pt});
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1; rx_sof = (i == 0); rx_eof = (i == len - 1);
      rx_crc_ok = crc && (i == len - 1); addr_match = am;
      if (i < 6)       rx_data = da[8*(5-i) +: 8];
      else if (i < 12) rx_data = 8'h20 + 8'(i);
      else if (i == 12) rx_data = ty[15:8];
      else if (i == 13) rx_data = ty[7:0];
      else if (i == 14) rx_data = op[15:8];
      else if (i == 15) rx_data = op[7:0];
      else if (i == 16) rx_data = pt[15:8];
      else if (i == 17) rx_data = pt[7:0];
      else rx_data = 8'(i);
    end
    @(negedge clk);
    rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_crc_ok = 0; addr_match = 0;
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && dec_valid) begin
      logic [19:0] e;
      if (expq.size() == 0) check(0, "R9 unexpected decision", 1, 0);
      else begin
        e = expq.pop_front();
        check(dec_forward == e[19], "R3/R5/R6 forward", int'(dec_forward), int'(e[19]));
        check(dec_ctrl == e[18], "R1 ctrl", int'(dec_ctrl), int'(e[18]));
        check(dec_pause == e[17], "R2 pause", int'(dec_pause), int'(e[17]));
        check(pause_req == e[16], "R4 request", int'(pause_req), int'(e[16]));
        if (e[16]) begin
          check(pause_time == e[15:0], "R4 time", int'(pause_time), int'(e[15:0]));
          check(tx_hold == (e[15:0] != 0), "R7 hold on load", int'(tx_hold), int'(e[15:0] != 0));
        end
      end
    end else if (rst_n) begin
      check(!pause_req, "R4 request outside decision", int'(pause_req), 0);
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); quanta_tick = 1;
      @(negedge clk); quanta_tick = 0;
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!dec_valid && !pause_req && !tx_hold, "R9 reset state", int'(tx_hold), 0);
    rst_n = 1;
    // R1 R3 normal frames
    send(UDA, 16'h0800, 16'h0000, 16'h0000, 60, 1, 1);
    send(UDA, 16'h0800, 16'h0000, 16'h0000, 60, 1, 0);
    send(UDA, 16'h0800, 16'h0000, 16'h0000, 60, 0, 1);
    // R2 R4 R5 pause with fc on, pass_all off, filter says no
    cfg_rx_fc_en = 1;
    send(RDA, 16'h8808, 16'h0001, 16'h1234, 60, 1, 0);
    send(RDA, 16'h8808, 16'h0001, 16'h0000, 60, 1, 0);
    // near misses
    send(48'h0180C2000002, 16'h8808, 16'h0001, 16'h0040, 60, 1, 1);
    send(RDA, 16'h8808, 16'h0002, 16'h0040, 60, 1, 0);
    send(RDA, 16'h8809, 16'h0001, 16'h0040, 60, 1, 0);
    send(RDA, 16'h8808, 16'h0001, 16'h0040, 17, 1, 0);
    send(RDA, 16'h8808, 16'h0001, 16'h0040, 18, 1, 0);
    send(UDA, 16'h8808, 16'h0000, 16'h0000, 13, 1, 1);
    // R6 pass all combinations
    cfg_pass_all = 1;
    send(RDA, 16'h8808, 16'h0001, 16'h0000, 60, 1, 0);
    send(UDA, 16'h8808, 16'h0005, 16'h0000, 60, 1, 1);
    send(UDA, 16'h8808, 16'h0005, 16'h0000, 60, 1, 0);
    cfg_rx_fc_en = 0;
    send(RDA, 16'h8808, 16'h0001, 16'h0077, 60, 1, 0);
    check(!tx_hold, "R4 fc disabled no hold", int'(tx_hold), 0);
    cfg_pass_all = 0;
    send(RDA, 16'h8808, 16'h0001, 16'h0077, 60, 1, 0);
    // R7 R8 counter
    cfg_rx_fc_en = 1;
    send(RDA, 16'h8808, 16'h0001, 16'h0003, 20, 1, 0);
    check(tx_hold, "R7 hold after load", int'(tx_hold), 1);
    tick(2);
    check(tx_hold, "R8 hold after 2 of 3 ticks", int'(tx_hold), 1);
    send(RDA, 16'h8808, 16'h0001, 16'h0009, 20, 0, 0);
    check(tx_hold, "R4 bad crc leaves hold", int'(tx_hold), 1);
    tick(1);
    check(!tx_hold, "R8 hold released after 3 ticks", int'(tx_hold), 0);
    send(RDA, 16'h8808, 16'h0001, 16'h0005, 20, 1, 0);
    tick(1);
    check(tx_hold, "R8 hold mid count", int'(tx_hold), 1);
    send(RDA, 16'h8808, 16'h0001, 16'h0000, 20, 1, 0);
    check(!tx_hold, "R7 zero releases at once", int'(tx_hold), 0);
    repeat (4) @(negedge clk);
    check(expq.size() == 0, "R9 all decisions seen", expq.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule